// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sets the power state of a small microcontroller through two 32-bit words on a simple read/write bus. Word 0 is the control word. It selects the supply-monitor enable and threshold, the backup-domain write enable, the ultra-low-power and fast-wakeup options, the core-voltage range, the regulator and deep-power-down choices for deep sleep, and the low-power-run request. Word 1 is the status word. It holds the latched wake and standby flags, the gated supply-monitor result, the voltage-scaling busy flag, the regulator-low-power flag and the per-pin wakeup enables.

When software changes the core-voltage range, the block raises a busy flag and asks for the system clock to stop. Both stay up until the regulator reports ready. Entry to and exit from low-power run follow a fixed order, and entry is refused outside the middle voltage range. After exit, the regulator-low-power flag stays set until the regulator is back in main mode. The wake and standby flags are cleared by write-one bits that sit two positions above them in the control word. A synchronous soft reset returns the control word to its defaults but keeps the two low-power option bits.

The regulator, the supply comparator and the real-time clock are not modelled. Each appears only as an input signal.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_1000 (range code 2 in bits [12:11], every other bit 0), the status word reads 0, and `lprun_req` and `clk_stop_req` are low.
- R2: Control word bits and the outputs that follow them: bit0 `reg_lp_sel`, bit1 `dpd_sel`, bit4 `mon_en`, bits [7:5] `mon_lvl`, bit8 `bkp_wr_en`, bit9 `ulp_en`, bit10 `fast_wake`, bits [12:11] `vrange`, bit14 `lprun_req`. Bits 2, 3, 13 and 15 to 31 always read 0. `bus_addr` 0 selects the control word and 1 selects the status word.
- R3: `mon_ext_sel` is high only when `mon_en` is 1 and `mon_lvl` is 7. Status bit2 follows `cmp_out` while `mon_en` is 1 and reads 0 while `mon_en` is 0.
- R4: A control update that changes bits [12:11] sets status bit4 and `clk_stop_req` at that same clock edge. Both stay set until `vreg_rdy` is sampled high.
- R5: A write to bits [12:11] is ignored while status bit4 is set or while bit14 is set.
- R6: Bit14 can go from 0 to 1 only if four conditions all hold: the current range is 2, the write leaves the range at 2, bit0 is already 1, and the write keeps bit0 at 1. Otherwise bit14 stays 0.
- R7: While bit14 is 1, bit0 cannot be cleared. A write that clears both bits clears only bit14.
- R8: Status bit5 is set on the edge after one at which bit14 is 1. After bit14 clears, bit5 stays set until `vreg_rdy` is sampled high, and then it clears.
- R9: Status bits [10:8] are writable. Bit 8+i enables `wk_pin[i]`. A 0-to-1 change on an enabled pin sets the wake flag (status bit0). A held high level, or an edge on a disabled pin, does nothing. `rtc_wake` high also sets the wake flag.
- R10: A `dsleep_stb` pulse while `dpd_sel` is 1 sets the standby flag (status bit1). Without `dpd_sel` the pulse has no effect.
- R11: Writing 1 to control bit2 clears the wake flag, and writing 1 to control bit3 clears the standby flag. A set event in the same cycle wins over the clear.
- R12: `soft_rst` returns the control word to the R1 default but keeps bits 9 and 10. A range change caused by `soft_rst` sets busy exactly as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous peripheral soft reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 1 | Word select: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| dsleep_stb | input | 1 | Deep-sleep entry strobe from the CPU |
| wk_pin | input | NPINS | Wakeup pins |
| rtc_wake | input | 1 | Real-time-clock wake event |
| cmp_out | input | 1 | Supply comparator result |
| vreg_rdy | input | 1 | Regulator ready handshake |
| mon_en | output | 1 | Supply monitor enable |
| mon_lvl | output | 3 | Supply monitor threshold code |
| mon_ext_sel | output | 1 | Monitor compares the external analog input |
| bkp_wr_en | output | 1 | Backup-domain write enable |
| ulp_en | output | 1 | Ultra-low-power option |
| fast_wake | output | 1 | Fast-wakeup option |
| vrange | output | 2 | Core-voltage range code |
| reg_lp_sel | output | 1 | Regulator low power in deep sleep |
| dpd_sel | output | 1 | Deep-power-down selected for deep sleep |
| lprun_req | output | 1 | Low-power-run request |
| clk_stop_req | output | 1 | System clock stop request |

## Verification
The bench goes after the handshake corners.

- **Range writes while busy or in low-power run.** A design that let these through would change the core voltage without the clock being stopped.
- **Entry to low-power run in the wrong range, or without bit0.** A wrong design would run the regulator in low-power mode at the wrong range.
- **Clearing bit0 while bit14 is set, and regulator-ready arriving late.** A wrong design would drop the regulator flag before main mode is back.
- **Pin edges.** The bench checks held levels, disabled pins, and a wake event that lands in the same cycle as a clear, which must not be lost.
- **Soft reset.** It must keep the two low-power bits while still starting a range change.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int DW   = 32;
  // control word bit positions
  localparam int B_RLP = 0;
  localparam int B_DPD = 1;
  localparam int B_CLRW = 2;
  localparam int B_CLRS = 3;
  localparam int B_MEN = 4;
  localparam int B_LVL = 5;
  localparam int LVLW  = 3;
  localparam int B_BKP = 8;
  localparam int B_ULP = 9;
  localparam int B_FWU = 10;
  localparam int B_VR  = 11;
  localparam int VRW   = 2;
  localparam int B_LPR = 14;
  // status word bit positions
  localparam int S_WK  = 0;
  localparam int S_SB  = 1;
  localparam int S_MON = 2;
  localparam int S_VSB = 4;
  localparam int S_RLP = 5;
  localparam int S_PEN = 8;
  localparam int CLR_GAP = B_CLRW - S_WK;

  localparam logic [VRW-1:0]  VR_DEFAULT = 2'b10;
  localparam logic [VRW-1:0]  VR_LPRUN   = 2'b10;
  localparam logic [LVLW-1:0] LVL_EXT    = 3'd7;

  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] CTRL_WMASK =
      (ONE << B_RLP) | (ONE << B_DPD) | (ONE << B_MEN) |
      (((ONE << LVLW) - ONE) << B_LVL) | (ONE << B_BKP) |
      (ONE << B_ULP) | (ONE << B_FWU) |
      (((ONE << VRW) - ONE) << B_VR) | (ONE << B_LPR);
  localparam logic [DW-1:0] CTRL_RST = DW'(VR_DEFAULT) << B_VR;

  // low-power run may start only in the run range with the regulator bit held
  function automatic logic lprun_allowed(input logic [DW-1:0] cur,
                                         input logic [DW-1:0] nxt);
    return (cur[B_VR +: VRW] == VR_LPRUN) && (nxt[B_VR +: VRW] == VR_LPRUN) &&
           cur[B_RLP] && nxt[B_RLP];
  endfunction

  // next control word for a bus write
  function automatic logic [DW-1:0] ctrl_update(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] wd,
                                                input logic busy);
    logic [DW-1:0] n;
    logic held;
    held = cur[B_LPR];
    n = wd & CTRL_WMASK;
    if (busy || held) n[B_VR +: VRW] = cur[B_VR +: VRW];
    if (!held && n[B_LPR] && !lprun_allowed(cur, n)) n[B_LPR] = 1'b0;
    if (held) n[B_RLP] = 1'b1;
    return n;
  endfunction

  // next control word for a soft reset
  function automatic logic [DW-1:0] ctrl_soft(input logic [DW-1:0] cur);
    logic [DW-1:0] n;
    n = CTRL_RST;
    n[B_ULP] = cur[B_ULP];
    n[B_FWU] = cur[B_FWU];
    return n;
  endfunction
endpackage

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [DW-1:0] ctrl_q,
  output logic          vr_change,
  output logic          clr_wake,
  output logic          clr_sb
);
  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (soft_rst)   ctrl_d = ctrl_soft(ctrl_q);
    else if (wr_en) ctrl_d = ctrl_update(ctrl_q, wdata, busy);
  end

  assign vr_change = (ctrl_d[B_VR +: VRW] != ctrl_q[B_VR +: VRW]);
  assign clr_wake  = wr_en && !soft_rst && wdata[S_WK + CLR_GAP];
  assign clr_sb    = wr_en && !soft_rst && wdata[S_SB + CLR_GAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  // R6: low-power run is only ever held in the run range
  a_r6_lprun_range: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_LPR] |-> (ctrl_q[B_VR +: VRW] == VR_LPRUN));
  // R7: regulator low-power bit stays while low-power run is set
  a_r7_rlp_held: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_LPR] |-> ctrl_q[B_RLP]);
  // R5: range is frozen while the busy flag is up
  a_r5_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst) |=> $stable(ctrl_q[B_VR +: VRW]));
endmodule

// File: rtl/lpm_reg_hs.sv
module lpm_reg_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic vr_change,
  input  logic lprun,
  input  logic vreg_rdy,
  output logic vs_busy,
  output logic rlp_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_busy  <= 1'b0;
      rlp_flag <= 1'b0;
    end else begin
      vs_busy  <= vr_change | (vs_busy & ~vreg_rdy);
      rlp_flag <= lprun | (rlp_flag & ~vreg_rdy);
    end
  end

  // R4: a range change raises busy and it holds until ready
  a_r4_busy_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    vr_change |=> vs_busy);
  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_busy && !vreg_rdy) |=> vs_busy);
  // R8: regulator flag only drops after the regulator reports ready
  a_r8_rlp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rlp_flag && !vreg_rdy) |=> rlp_flag);
  a_r8_rlp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rlp_flag) |-> ($past(vreg_rdy) && !$past(lprun)));
endmodule

// File: rtl/lpm_flags.sv
module lpm_flags #(
  parameter int NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pen_we,
  input  logic [NPINS-1:0] pen_wd,
  input  logic [NPINS-1:0] wk_pin,
  input  logic             rtc_wake,
  input  logic             dsleep_stb,
  input  logic             dpd_sel,
  input  logic             clr_wake,
  input  logic             clr_sb,
  output logic [NPINS-1:0] pin_en,
  output logic             wake_flag,
  output logic             sb_flag
);
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] rise;
  logic             wake_evt;
  logic             sb_evt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign rise[i] = wk_pin[i] & ~pin_q[i] & pin_en[i];
  end

  assign wake_evt = (|rise) | rtc_wake;
  assign sb_evt   = dsleep_stb & dpd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= '0;
      pin_en    <= '0;
      wake_flag <= 1'b0;
      sb_flag   <= 1'b0;
    end else begin
      pin_q <= wk_pin;
      if (pen_we) pin_en <= pen_wd;
      if (wake_evt)      wake_flag <= 1'b1;
      else if (clr_wake) wake_flag <= 1'b0;
      if (sb_evt)        sb_flag <= 1'b1;
      else if (clr_sb)   sb_flag <= 1'b0;
    end
  end

  // R9: wake flag only rises after an enabled edge or a clock event
  a_r9_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(wake_evt));
  // R11: a clear with no competing event empties the flag
  a_r11_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wake && !wake_evt) |=> !wake_flag);
  // R10: standby flag only rises after a strobe with deep power-down chosen
  a_r10_sb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_flag) |-> $past(sb_evt));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             dsleep_stb,
  input  logic [NPINS-1:0] wk_pin,
  input  logic             rtc_wake,
  input  logic             cmp_out,
  input  logic             vreg_rdy,
  output logic             mon_en,
  output logic [2:0]       mon_lvl,
  output logic             mon_ext_sel,
  output logic             bkp_wr_en,
  output logic             ulp_en,
  output logic             fast_wake,
  output logic [1:0]       vrange,
  output logic             reg_lp_sel,
  output logic             dpd_sel,
  output logic             lprun_req,
  output logic             clk_stop_req
);
  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    stat_word;
  logic             wr_ctrl, wr_stat;
  logic             vr_change, clr_wake, clr_sb;
  logic             vs_busy, rlp_flag;
  logic             wake_flag, sb_flag;
  logic [NPINS-1:0] pin_en;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == 1'b0);
  assign wr_stat = bus_sel && bus_wr && (bus_addr == 1'b1);

  lpm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_ctrl),
    .wdata(bus_wdata), .busy(vs_busy), .ctrl_q(ctrl_q),
    .vr_change(vr_change), .clr_wake(clr_wake), .clr_sb(clr_sb)
  );

  lpm_reg_hs u_hs (
    .clk(clk), .rst_n(rst_n), .vr_change(vr_change), .lprun(ctrl_q[B_LPR]),
    .vreg_rdy(vreg_rdy), .vs_busy(vs_busy), .rlp_flag(rlp_flag)
  );

  lpm_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .pen_we(wr_stat),
    .pen_wd(bus_wdata[S_PEN +: NPINS]), .wk_pin(wk_pin), .rtc_wake(rtc_wake),
    .dsleep_stb(dsleep_stb), .dpd_sel(ctrl_q[B_DPD]), .clr_wake(clr_wake),
    .clr_sb(clr_sb), .pin_en(pin_en), .wake_flag(wake_flag), .sb_flag(sb_flag)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[S_WK]           = wake_flag;
    stat_word[S_SB]           = sb_flag;
    stat_word[S_MON]          = cmp_out & ctrl_q[B_MEN];
    stat_word[S_VSB]          = vs_busy;
    stat_word[S_RLP]          = rlp_flag;
    stat_word[S_PEN +: NPINS] = pin_en;
  end

  assign bus_rdata    = bus_addr ? stat_word : ctrl_q;
  assign mon_en       = ctrl_q[B_MEN];
  assign mon_lvl      = ctrl_q[B_LVL +: LVLW];
  assign mon_ext_sel  = ctrl_q[B_MEN] && (ctrl_q[B_LVL +: LVLW] == LVL_EXT);
  assign bkp_wr_en    = ctrl_q[B_BKP];
  assign ulp_en       = ctrl_q[B_ULP];
  assign fast_wake    = ctrl_q[B_FWU];
  assign vrange       = ctrl_q[B_VR +: VRW];
  assign reg_lp_sel   = ctrl_q[B_RLP];
  assign dpd_sel      = ctrl_q[B_DPD];
  assign lprun_req    = ctrl_q[B_LPR];
  assign clk_stop_req = vs_busy;

  // R4: every range change at the pins comes with a clock stop request
  a_r4_clk_stop_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vrange) |-> clk_stop_req);
  // R12: soft reset leaves both low-power options untouched
  a_r12_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ulp_en == $past(ulp_en)) && (fast_wake == $past(fast_wake)));
  // R6: low-power run is never requested outside the run range
  a_r6_req_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lprun_req) |-> $past(vrange) == 2'b10);
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dsleep_stb = 1'b0;
  logic [2:0]  wk_pin = '0;
  logic        rtc_wake = 1'b0, cmp_out = 1'b0, vreg_rdy = 1'b0;
  logic        mon_en, mon_ext_sel, bkp_wr_en, ulp_en, fast_wake;
  logic [2:0]  mon_lvl;
  logic [1:0]  vrange;
  logic        reg_lp_sel, dpd_sel, lprun_req, clk_stop_req;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dsleep_stb(dsleep_stb), .wk_pin(wk_pin),
    .rtc_wake(rtc_wake), .cmp_out(cmp_out), .vreg_rdy(vreg_rdy),
    .mon_en(mon_en), .mon_lvl(mon_lvl), .mon_ext_sel(mon_ext_sel),
    .bkp_wr_en(bkp_wr_en), .ulp_en(ulp_en), .fast_wake(fast_wake),
    .vrange(vrange), .reg_lp_sel(reg_lp_sel), .dpd_sel(dpd_sel),
    .lprun_req(lprun_req), .clk_stop_req(clk_stop_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rdy_pulse();
    vreg_rdy = 1'b1;
    @(negedge clk);
    vreg_rdy = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  // bench view of a control write, from R2, R5, R6 and R7
  function automatic logic [31:0] m_upd(input logic [31:0] c, input logic [31:0] w,
                                        input logic b);
    logic [31:0] n;
    n = w & 32'h0000_5FF3;
    if (b || c[14]) n[12:11] = c[12:11];
    if (!c[14] && n[14]) begin
      if (!(c[12:11] == 2'd2 && n[12:11] == 2'd2 && c[0] && n[0])) n[14] = 1'b0;
    end
    if (c[14]) n[0] = 1'b1;
    return n;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      nerr++;
      $display("FAIL watchdog: actual=stalled expected=finished");
      report();
    end
  end

  logic [31:0] r, exp_c, w;
  logic        exp_b, exp_r, rdy, old_l;

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    rd(0, r); chk("R1 ctrl reset", r, 32'h0000_1000);
    rd(1, r); chk("R1 status reset", r, 32'h0);
    chk("R1 outputs reset", {30'd0, lprun_req, clk_stop_req}, 32'd0);

    // random control writes against the bench model (R2 R4 R5 R6 R7 R8)
    exp_c = 32'h0000_1000; exp_b = 1'b0; exp_r = 1'b0;
    for (int i = 0; i < 300; i++) begin
      w = $urandom;
      if ($urandom % 3 == 0) w[12:11] = 2'd2;
      if ($urandom % 2 == 0) w[0] = 1'b1;
      old_l = exp_c[14];
      wr(0, w);
      begin
        logic [31:0] n;
        n = m_upd(exp_c, w, exp_b);
        if (n[12:11] != exp_c[12:11]) exp_b = 1'b1;
        exp_r = old_l | exp_r;
        exp_c = n;
      end
      rdy = 1'($urandom % 2);
      vreg_rdy = rdy;
      tick();
      vreg_rdy = 1'b0;
      exp_r = exp_c[14] | (exp_r & ~rdy);
      exp_b = exp_b & ~rdy;
      rd(0, r); chk("R2/R5/R6/R7 random ctrl", r, exp_c);
      rd(1, r); chk("R4/R8 random busy and regulator flag", {26'd0, r[5:4]}, {26'd0, exp_r, exp_b});
    end

    do_reset();
    // R2 field mapping
    wr(0, 32'hFFFF_BFFF);
    rd(0, r); chk("R2 ctrl readback", r, 32'h0000_1FF3);
    chk("R2 output fields",
        {20'd0, mon_en, mon_lvl, bkp_wr_en, ulp_en, fast_wake, vrange, reg_lp_sel, dpd_sel},
        {20'd0, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1});
    chk("R3 external level select", {31'd0, mon_ext_sel}, 32'd1);
    // R4 busy and clock stop held until ready
    rd(1, r); chk("R4 busy set", {31'd0, r[4]}, 32'd1);
    repeat (3) tick();
    chk("R4 clock stop held", {31'd0, clk_stop_req}, 32'd1);
    // R5 range write while busy
    wr(0, 32'h0000_0FF3);
    rd(0, r); chk("R5 range kept while busy", r, 32'h0000_1FF3);
    rdy_pulse();
    rd(1, r); chk("R4 busy cleared by ready", {31'd0, r[4]}, 32'd0);
    chk("R4 clock stop released", {31'd0, clk_stop_req}, 32'd0);
    // R3 monitor gating
    cmp_out = 1'b1; #1;
    rd(1, r); chk("R3 monitor visible when enabled", {31'd0, r[2]}, 32'd1);
    wr(0, 32'h0000_1800);
    rd(1, r); chk("R3 monitor reads 0 when disabled", {31'd0, r[2]}, 32'd0);
    wr(0, 32'h0000_18D0);
    chk("R3 level 6 is internal", {31'd0, mon_ext_sel}, 32'd0);
    cmp_out = 1'b0;
    // R6 entry refused in range 3
    wr(0, 32'h0000_1801);
    wr(0, 32'h0000_5801);
    rd(0, r); chk("R6 refused outside range 2", r, 32'h0000_1801);
    wr(0, 32'h0000_1000);
    rdy_pulse();
    wr(0, 32'h0000_5001);
    rd(0, r); chk("R6 refused without bit0 first", r, 32'h0000_1001);
    wr(0, 32'h0000_5001);
    chk("R6 accepted", {31'd0, lprun_req}, 32'd1);
    tick();
    rd(1, r); chk("R8 regulator flag set", {31'd0, r[5]}, 32'd1);
    // R5 range write during low-power run
    wr(0, 32'h0000_6001);
    rd(0, r); chk("R5 range kept during low-power run", r, 32'h0000_5001);
    chk("R5 no busy during low-power run", {31'd0, clk_stop_req}, 32'd0);
    // R7 exit order
    wr(0, 32'h0000_4000);
    rd(0, r); chk("R7 bit0 held in low-power run", r, 32'h0000_5001);
    wr(0, 32'h0000_1000);
    rd(0, r); chk("R7 only run bit cleared", r, 32'h0000_1001);
    wr(0, 32'h0000_1000);
    rd(0, r); chk("R7 bit0 cleared afterwards", r, 32'h0000_1000);
    repeat (3) tick();
    rd(1, r); chk("R8 flag stays until ready", {31'd0, r[5]}, 32'd1);
    rdy_pulse();
    rd(1, r); chk("R8 flag cleared by ready", {31'd0, r[5]}, 32'd0);

    // R9 wakeup pins
    wr(1, 32'h0000_0200);
    rd(1, r); chk("R9 pin enables", {29'd0, r[10:8]}, 32'd2);
    wk_pin = 3'b001; tick();
    rd(1, r); chk("R9 disabled pin ignored", {31'd0, r[0]}, 32'd0);
    wk_pin = 3'b011; tick();
    rd(1, r); chk("R9 enabled rising edge", {31'd0, r[0]}, 32'd1);
    wr(0, 32'h0000_1004);
    rd(1, r); chk("R11 wake cleared", {31'd0, r[0]}, 32'd0);
    rd(0, r); chk("R11 clear bit reads 0", r, 32'h0000_1000);
    repeat (2) tick();
    rd(1, r); chk("R9 held level does not set", {31'd0, r[0]}, 32'd0);
    wk_pin = 3'b000;
    rtc_wake = 1'b1;
    wr(0, 32'h0000_1004);
    rtc_wake = 1'b0;
    rd(1, r); chk("R11 set wins over clear", {31'd0, r[0]}, 32'd1);
    wr(0, 32'h0000_1004);
    rtc_wake = 1'b1; tick(); rtc_wake = 1'b0;
    rd(1, r); chk("R9 clock wake event", {31'd0, r[0]}, 32'd1);

    // R10 standby flag
    dsleep_stb = 1'b1; tick(); dsleep_stb = 1'b0;
    rd(1, r); chk("R10 no standby without deep power-down", {31'd0, r[1]}, 32'd0);
    wr(0, 32'h0000_1002);
    dsleep_stb = 1'b1; tick(); dsleep_stb = 1'b0;
    rd(1, r); chk("R10 standby set", {31'd0, r[1]}, 32'd1);
    wr(0, 32'h0000_100A);
    rd(1, r); chk("R11 standby cleared", {31'd0, r[1]}, 32'd0);
    rd(0, r); chk("R11 ctrl after standby clear", r, 32'h0000_1002);

    // R12 soft reset
    wr(0, 32'h0000_0FF3);
    rdy_pulse();
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    rd(0, r); chk("R12 soft reset keeps bits 9 and 10", r, 32'h0000_1600);
    chk("R12 range change from soft reset sets busy", {31'd0, clk_stop_req}, 32'd1);

    done = 1;
    report();
  end
endmodule